// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A single-cycle start pulse captures the first column, a 3-bit burst-length code and a wrap-order select. From the next cycle on, the block presents the burst's columns in order. Each column comes with a valid flag, and the final column of a fixed-length burst also carries a last flag. The surrounding controller uses these addresses to line up data beats with columns.

Two wrap orders are provided. The sequential order counts upward inside the aligned block that the burst length defines. The interleaved order XORs the step number into the low bits of the first column. A full-page length is available only with the sequential order. It walks the whole row, rolls over from the top column to column 0, and runs until the controller stops it. A burst can be cut short on any cycle by a terminate input. A start pulse that arrives during a burst drops the rest of that burst and begins the new one on the following cycle.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset `valid_o` and `last_o` are 0, and they stay 0 until a start pulse.
- R2: A start pulse sampled at a clock edge makes `valid_o` 1 after that edge, and `col_o` shows the start column.
- R3: In sequential order with length BL of 2, 4 or 8, step i shows the start column with its low log2(BL) bits replaced by (low bits + i) mod BL. The upper bits keep their start value.
- R4: In interleaved order (`ilv_i`=1) with length BL of 2, 4 or 8, step i shows the start column with its low log2(BL) bits XORed with i.
- R5: The full-page code 111 in sequential order produces start, start+1, and so on, modulo 512, so column 511 is followed by 0. The burst never ends by itself and `last_o` is never 1.
- R6: The length code selects 000 = 1, 001 = 2, 010 = 4, 011 = 8 and 111 = full page. The codes 100, 101 and 110 give a burst of length 1.
- R7: Code 111 with interleaved order gives a burst of length 1.
- R8: `last_o` is 1 exactly with the final column of a fixed-length burst, and only while `valid_o` is 1. The cycle after it, `valid_o` is 0 unless a new start was sampled.
- R9: When `term_i` is 1 in a cycle where `valid_o` is 1, the column shown in that cycle is the final one, and `valid_o` is 0 in the next cycle.
- R10: A start pulse during a burst begins the new sequence in the next cycle and drops the old one. Start takes priority over `term_i` sampled at the same edge.
- R11: `term_i` has no effect while no burst is active: `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a new burst (one-cycle pulse) |
| start_col_i | input | 9 | First column of the burst |
| bl_code_i | input | 3 | Burst-length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Terminate the burst in progress |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | `col_o` holds a burst column |
| last_o | output | 1 | Final column of a fixed-length burst |

## Verification
A wrong step counter or a wrong span mask shows up as a wrong `col_o` in the very first cycle after the bad step. It appears as soon as the step index reaches a bit the mask should or should not cover. A wrongly captured length shows as `last_o` arriving early, late or never, or as `valid_o` staying high past the burst end, one cycle after the expected end. Priority faults between start, terminate and end of burst appear in the cycle right after the colliding edge. In that cycle an old-burst column appears where a new start column is expected.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

   typedef enum logic [2:0] {
      BLC_ONE  = 3'b000,
      BLC_TWO  = 3'b001,
      BLC_FOUR = 3'b010,
      BLC_EIGHT= 3'b011,
      BLC_PAGE = 3'b111
   } bl_code_e;

   // low-bit span (log2 of length) for a fixed code; 0 for unsupported
   function automatic int unsigned fixed_span(input logic [2:0] code);
      case (code)
         BLC_TWO:   return 1;
         BLC_FOUR:  return 2;
         BLC_EIGHT: return 3;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/sdr_bl_decode.sv
module sdr_bl_decode
   import sdr_burst_pkg::*;
#(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
)(
   input  logic [2:0]       code_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o
);
   localparam int MAX_FIXED = 3;

   generate
      if (COL_W <= MAX_FIXED) begin : g_bad_width
         $error("sdr_bl_decode: COL_W must exceed the largest fixed span");
      end
   endgenerate

   logic page_ok;
   logic [COL_W-1:0] fixed_mask;

   generate
      if (ILV_EN) begin : g_ilv_rule
         assign page_ok = (code_i == BLC_PAGE) && !ilv_i;
      end else begin : g_seq_only
         assign page_ok = (code_i == BLC_PAGE);
      end
   endgenerate

   always_comb begin
      fixed_mask = '0;
      for (int b = 0; b < MAX_FIXED; b++) begin
         if (b < int'(fixed_span(code_i))) fixed_mask[b] = 1'b1;
      end
   end

   assign full_o = page_ok;
   assign mask_o = page_ok ? {COL_W{1'b1}} : fixed_mask;

   // R6: span mask is always a run of ones starting at bit 0
   always_comb begin
      a_r6_mask_shape: assert (((mask_o + 1'b1) & mask_o) == '0)
         else $error("R6 span mask not contiguous");
   end

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
)(
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] step_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] sum;
   assign sum = base_i + step_i;

   genvar b;
   generate
      for (b = 0; b < COL_W; b++) begin : g_bit
         logic seq_bit;
         logic mix_bit;
         assign seq_bit = sum[b];
         if (ILV_EN) begin : g_mix
            assign mix_bit = ilv_i ? (base_i[b] ^ step_i[b]) : seq_bit;
         end else begin : g_plain
            assign mix_bit = seq_bit;
         end
         assign col_o[b] = mask_i[b] ? mix_bit : base_i[b];
      end
   endgenerate

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl #(
   parameter int COL_W = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [COL_W-1:0] mask_d_i,
   input  logic             full_d_i,
   input  logic             ilv_d_i,
   input  logic             term_i,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] step_o,
   output logic [COL_W-1:0] mask_o,
   output logic             ilv_o,
   output logic             valid_o,
   output logic             last_o
);
   logic [COL_W-1:0] base_q, step_q, mask_q;
   logic             full_q, ilv_q, valid_q;
   logic             at_end;

   assign at_end = !full_q && (step_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         step_q  <= '0;
         base_q  <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         ilv_q   <= 1'b0;
      end else if (start_i) begin
         valid_q <= 1'b1;
         step_q  <= '0;
         base_q  <= start_col_i;
         mask_q  <= mask_d_i;
         full_q  <= full_d_i;
         ilv_q   <= ilv_d_i;
      end else if (valid_q) begin
         if (term_i || at_end) valid_q <= 1'b0;
         else                  step_q  <= step_q + 1'b1;
      end
   end

   assign base_o  = base_q;
   assign step_o  = step_q;
   assign mask_o  = mask_q;
   assign ilv_o   = ilv_q;
   assign valid_o = valid_q;
   assign last_o  = valid_q && at_end;

   // R8: burst leaves the active state right after its final column
   a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !start_i |=> !valid_o);
   // R9: terminate closes the burst on the next cycle
   a_r9_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && term_i && !start_i |=> !valid_o);
   // R5: a burst that is neither terminated nor at its end keeps going
   a_r5_continue: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !last_o && !term_i |=> valid_o);

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       bl_code_i,
   input  logic             ilv_i,
   input  logic             term_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   logic [COL_W-1:0] mask_d, base_q, step_q, mask_q;
   logic             full_d, ilv_q;

   sdr_bl_decode #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_dec (
      .code_i (bl_code_i),
      .ilv_i  (ilv_i),
      .mask_o (mask_d),
      .full_o (full_d)
   );

   sdr_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .mask_d_i    (mask_d),
      .full_d_i    (full_d),
      .ilv_d_i     (ilv_i),
      .term_i      (term_i),
      .base_o      (base_q),
      .step_o      (step_q),
      .mask_o      (mask_q),
      .ilv_o       (ilv_q),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   sdr_col_gen #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_gen (
      .base_i (base_q),
      .step_i (step_q),
      .mask_i (mask_q),
      .ilv_i  (ilv_q),
      .col_o  (col_o)
   );

   // R2 / R10: the cycle after a start shows the new start column
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o && (col_o == $past(start_col_i)));
   // R8: last flag only on a valid column
   a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);
   // R5: a sequential full-page start never shows last on its first column
   a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && (bl_code_i == 3'b111) && !ilv_i |=> !last_o);
   // R11: without a start, an idle block stays idle
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o && !start_i |=> !valid_o);

endmodule

// File: tb/sim_sdr_burst_seq.sv
`timescale 1ns/1ps
module sim_sdr_burst_seq;
   localparam int CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] start_col_i = '0;
   logic [2:0]    bl_code_i = '0;
   logic          ilv_i = 1'b0;
   logic          term_i = 1'b0;
   logic [CW-1:0] col_o;
   logic          valid_o, last_o;

   always #4 clk = ~clk;

   sdr_burst_seq #(.COL_W(CW), .ILV_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .bl_code_i(bl_code_i), .ilv_i(ilv_i), .term_i(term_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   typedef struct {
      logic [CW-1:0] col;
      logic          last;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   mon_on = 1'b0;
   bit   done = 1'b0;

   // monitor: compare every valid column with the scoreboard head
   always @(negedge clk) begin
      if (mon_on && valid_o) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R8 unexpected valid col=%0d expected no burst", col_o);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (col_o !== e.col || last_o !== e.last) begin
               n_bad++;
               $display("FAIL %s col=%0d last=%0b expected col=%0d last=%0b",
                        e.tag, col_o, last_o, e.col, e.last);
            end
         end
      end
   end

   function automatic int span_of(input logic [2:0] code, input logic ilv);
      case (code)
         3'b001: return 1;
         3'b010: return 2;
         3'b011: return 3;
         3'b111: return ilv ? 0 : CW;
         default: return 0;
      endcase
   endfunction

   function automatic logic [CW-1:0] exp_col(input logic [CW-1:0] base,
         input int i, input int span, input logic ilv);
      int blk, lo;
      blk = 1 << span;
      lo  = int'(base) % blk;
      if (ilv) lo = lo ^ i;
      else     lo = (lo + i) % blk;
      return CW'((int'(base) / blk) * blk + lo);
   endfunction

   // driver: called at a negedge; stop=0 runs the natural length
   task automatic burst(input logic [CW-1:0] col, input logic [2:0] code,
         input logic ilv, input int stop, input bit use_term, input bit chain,
         input bit term_at_start, input string tag);
      int span, len, n;
      bit page;
      span = span_of(code, ilv);
      page = (code == 3'b111) && !ilv;
      len  = 1 << span;
      n    = (stop > 0 && (page || stop < len)) ? stop : len;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.col  = exp_col(col, i, span, ilv);
         e.last = !page && (i == len - 1);
         e.tag  = tag;
         exp_q.push_back(e);
      end
      start_i = 1'b1; start_col_i = col; bl_code_i = code; ilv_i = ilv;
      term_i  = term_at_start;
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         if (j == 0) begin start_i = 1'b0; term_i = 1'b0; end
         if (j == n - 1 && use_term) term_i = 1'b1;
      end
      if (!chain) begin
         @(negedge clk);
         term_i = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic chk(input bit cond, input string msg);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s", msg);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(valid_o === 1'b0 && last_o === 1'b0,
          $sformatf("R1 reset valid=%0b last=%0b expected 0 0", valid_o, last_o));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(valid_o === 1'b0, $sformatf("R1 idle valid=%0b expected 0", valid_o));
      mon_on = 1'b1;

      burst(9'd37,  3'b000, 1'b0, 0, 0, 0, 0, "R2 R6 seq len1");
      burst(9'd5,   3'b001, 1'b0, 0, 0, 0, 0, "R3 seq len2");
      burst(9'd422, 3'b010, 1'b0, 0, 0, 0, 0, "R3 seq len4");
      burst(9'd13,  3'b011, 1'b0, 0, 0, 0, 0, "R3 R8 seq len8");
      burst(9'd422, 3'b010, 1'b1, 0, 0, 0, 0, "R4 ilv len4");
      burst(9'd13,  3'b011, 1'b1, 0, 0, 0, 0, "R4 R8 ilv len8");
      burst(9'd300, 3'b001, 1'b1, 0, 0, 0, 0, "R4 ilv len2");
      burst(9'd77,  3'b100, 1'b0, 0, 0, 0, 0, "R6 code100");
      burst(9'd78,  3'b101, 1'b1, 0, 0, 0, 0, "R6 code101");
      burst(9'd79,  3'b110, 1'b0, 0, 0, 0, 0, "R6 code110");
      burst(9'd250, 3'b111, 1'b1, 0, 0, 0, 0, "R7 page ilv");
      burst(9'd505, 3'b111, 1'b0, 520, 1, 0, 0, "R5 page wrap");
      burst(9'd64,  3'b011, 1'b0, 3, 1, 0, 0, "R9 term len8");
      burst(9'd2,   3'b010, 1'b0, 4, 1, 0, 0, "R9 term on last");
      // R10: restart mid-burst, then start together with term
      burst(9'd16,  3'b011, 1'b0, 3, 0, 1, 0, "R10 first");
      burst(9'd200, 3'b010, 1'b1, 2, 0, 1, 0, "R10 second");
      burst(9'd91,  3'b001, 1'b0, 0, 0, 1, 1, "R10 start beats term");
      burst(9'd40,  3'b010, 1'b0, 0, 0, 0, 0, "R8 back to back");

      // R11: terminate while idle
      term_i = 1'b1;
      @(negedge clk);
      term_i = 1'b0;
      @(negedge clk);
      chk(valid_o === 1'b0, $sformatf("R11 valid=%0b expected 0", valid_o));
      repeat (2) @(negedge clk);

      chk(exp_q.size() == 0,
          $sformatf("R8 pending=%0d expected 0", exp_q.size()));
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule